// File: doc/BRIEF.md
# Shift-Register Counting Membership Filter

This block holds the counter table of a counting Bloom filter. The table has 2^ADDR_W rows. Each row is one 8-bit counter and its own zero detector. The counter is not a binary counter. It is a reversible Galois shift register with XNOR feedback: one step forward adds one to the count, and one step backward removes one. Hash logic outside the block gives a row address and one operation each cycle. Insert and delete step the addressed counter. A probe reports whether the addressed counter stands at zero.

The rows are grouped into 2^PART_W partitions. The upper address bits pick the partition and the lower bits pick a row inside it. Each partition sends out one local zero line for its selected row. A final multiplexer picks the zero line of the addressed partition. The probe result is registered and held until the next probe. The counts saturate: stepping below zero or above the highest count leaves the counter where it is.

Top module: `lfsr_cbf_array`

## Requirements
- R1: The op_sel encodings are 2'b00 idle, 2'b01 increment, 2'b10 decrement and 2'b11 probe. Only the addressed row is acted on.
- R2: While reset is asserted, and after it is released, every counter holds count zero (all-zeros state) and is_zero reads 1.
- R3: A probe sampled on a clock edge drives is_zero to 1 after that edge when the addressed counter's count is zero, and to 0 otherwise.
- R4: is_zero keeps its last value through every cycle whose operation is not probe.
- R5: An increment raises the addressed counter's count by one and a decrement lowers it by one. A probe in the next cycle sees the new count.
- R6: A decrement on a counter at count zero leaves it at zero.
- R7: An increment on a counter at the highest count, 254, leaves it at 254. The all-ones state is never used.
- R8: A counter's state for count k is the state reached by stepping k times from all zeros. One step forward sets new bit 7 to old bit 0. It sets new bit i (i<7) to old bit i+1, XNORed with old bit 0 where tap mask 8'hB8 has a one. A backward step is the exact inverse of a forward step.
- R9: addr[ADDR_W-1 -: PART_W] selects the partition and addr[ADDR_W-PART_W-1:0] selects the row. Stepping one row never changes the count seen by a probe of any other row.
- R10: An idle cycle changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_sel | input | 2 | Operation: idle, increment, decrement or probe |
| addr | input | ADDR_W | Row address: partition field above row field |
| is_zero | output | 1 | Registered probe result: addressed counter is at zero |

## Verification
An increment or decrement takes effect on the edge that samples it. A probe in the very next cycle therefore already sees the new count. A probe result appears on is_zero right after the edge that samples the probe, and it stays there through every non-probe cycle. The bench drives inputs on the falling edge and updates its integer reference on the rising edge. On the following falling edge it compares is_zero with the reference, so every clock is checked exactly one register after the stimulus that set it.

// File: rtl/lfsr_cbf_pkg.sv
package lfsr_cbf_pkg;
  localparam int CNT_W = 8;
  localparam logic [CNT_W-1:0] TAP_MASK = 8'hB8;
  localparam logic [CNT_W-1:0] ZERO_ST = '0;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_INC   = 2'b01,
    OP_DEC   = 2'b10,
    OP_PROBE = 2'b11
  } cbf_op_e;

  // one forward step: Galois right shift, tapped bits XNOR feedback
  function automatic logic [CNT_W-1:0] lfsr_fwd(input logic [CNT_W-1:0] s);
    logic [CNT_W-1:0] n;
    n[CNT_W-1] = s[0];
    for (int i = 0; i < CNT_W-1; i++)
      n[i] = TAP_MASK[i] ? ~(s[i+1] ^ s[0]) : s[i+1];
    return n;
  endfunction

  // one backward step: reciprocal left shift, exact inverse of lfsr_fwd
  function automatic logic [CNT_W-1:0] lfsr_rev(input logic [CNT_W-1:0] s);
    logic [CNT_W-1:0] n;
    n[0] = s[CNT_W-1];
    for (int i = 0; i < CNT_W-1; i++)
      n[i+1] = TAP_MASK[i] ? ~(s[i] ^ s[CNT_W-1]) : s[i];
    return n;
  endfunction

  // state one step before wrapping back to zero: highest count
  localparam logic [CNT_W-1:0] TOP_ST = lfsr_rev(ZERO_ST);
endpackage

// File: rtl/lfsr_cbf_cell.sv
module lfsr_cbf_cell
  import lfsr_cbf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic dir_up,
  output logic cnt_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d, up_v, dn_v, shift_v;
  logic             blocked;

  always_comb begin
    up_v = lfsr_fwd(cnt_q);
    dn_v = lfsr_rev(cnt_q);
  end

  // per-bit direction multiplexer
  for (genvar b = 0; b < CNT_W; b++) begin : g_dir_mux
    assign shift_v[b] = dir_up ? up_v[b] : dn_v[b];
  end

  always_comb begin
    blocked = dir_up ? (cnt_q == TOP_ST) : (cnt_q == ZERO_ST);
    cnt_d   = cnt_q;
    if (!blocked) cnt_d = shift_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= ZERO_ST;
    else if (step_en) cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == ZERO_ST);

  // R7
  illegal_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != '1);
  // R6
  dec_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !dir_up && cnt_zero) |=> cnt_zero);
  // R7
  inc_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && dir_up && cnt_q == TOP_ST) |=> (cnt_q == TOP_ST));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt_q));
  // R8
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && dir_up && cnt_zero) |=> !cnt_zero);
endmodule

// File: rtl/lfsr_cbf_part.sv
module lfsr_cbf_part #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             part_hit,
  input  logic             step_req,
  input  logic             dir_up,
  input  logic [ROW_W-1:0] row_sel,
  output logic             loc_zero
);
  localparam int ROWS = 1 << ROW_W;

  logic [ROWS-1:0] row_hit, row_zero;

  // local decode
  always_comb begin
    row_hit          = '0;
    row_hit[row_sel] = part_hit;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    lfsr_cbf_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (row_hit[r] & step_req),
      .dir_up   (dir_up),
      .cnt_zero (row_zero[r])
    );
  end

  // shared local zero line
  assign loc_zero = row_zero[row_sel];

  // R9
  row_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_hit));
endmodule

// File: rtl/lfsr_cbf_array.sv
module lfsr_cbf_array
  import lfsr_cbf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PART_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        op_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_zero
);
  localparam int ROW_W = ADDR_W - PART_W;
  localparam int NPART = 1 << PART_W;

  logic              rst_meta, rst_n_int;
  cbf_op_e           op;
  logic              step_req, dir_up, zero_d, zero_mux;
  logic [PART_W-1:0] part_idx;
  logic [ROW_W-1:0]  row_idx;
  logic [NPART-1:0]  part_hit, part_zero;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  assign op       = cbf_op_e'(op_sel);
  assign step_req = (op == OP_INC) || (op == OP_DEC);
  assign dir_up   = (op == OP_INC);
  assign part_idx = addr[ADDR_W-1 -: PART_W];
  assign row_idx  = addr[ROW_W-1:0];

  // global decode
  always_comb begin
    part_hit           = '0;
    part_hit[part_idx] = 1'b1;
  end

  for (genvar p = 0; p < NPART; p++) begin : g_part
    lfsr_cbf_part #(.ROW_W(ROW_W)) u_part (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .part_hit (part_hit[p]),
      .step_req (step_req),
      .dir_up   (dir_up),
      .row_sel  (row_idx),
      .loc_zero (part_zero[p])
    );
  end

  // output multiplexer and result register
  assign zero_mux = part_zero[part_idx];

  always_comb begin
    zero_d = is_zero;
    if (op == OP_PROBE) zero_d = zero_mux;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) is_zero <= 1'b1;
    else            is_zero <= zero_d;
  end

  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op != OP_PROBE) |=> $stable(is_zero));
  // R9
  part_decode_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(part_hit));
  // R3
  probe_result_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (op == OP_PROBE) |=> (is_zero == $past(zero_mux)));
endmodule

// File: tb/lfsr_cbf_array_tb.sv
module lfsr_cbf_array_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 6;
  localparam int NROWS  = 1 << ADDR_W;
  localparam int MAXC   = 254;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        op_sel;
  logic [ADDR_W-1:0] addr;
  logic              is_zero;

  int    cnt [NROWS];
  logic  exp_zero;
  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R2";
  bit    done = 0;

  always #(CLK_P/2) clk = ~clk;

  lfsr_cbf_array #(.ADDR_W(ADDR_W), .PART_W(2)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_sel  (op_sel),
    .addr    (addr),
    .is_zero (is_zero)
  );

  task automatic check_out();
    n_chk++;
    if (is_zero !== exp_zero) begin
      n_bad++;
      $display("FAIL %s: is_zero=%0b expected %0b at %0t", tag, is_zero, exp_zero, $time);
    end
  endtask

  // R1 encodings: 0 idle, 1 inc, 2 dec, 3 probe
  task automatic do_op(input logic [1:0] op, input int a);
    @(negedge clk);
    check_out();
    op_sel = op;
    addr   = a[ADDR_W-1:0];
    @(posedge clk);
    case (op)
      2'b01: if (cnt[a] < MAXC) cnt[a]++;
      2'b10: if (cnt[a] > 0) cnt[a]--;
      2'b11: exp_zero = (cnt[a] == 0);
      default: ;
    endcase
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NROWS; i++) cnt[i] = 0;
    exp_zero = 1'b1;
    rst_n = 1'b0; op_sel = 2'b00; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); check_out();          // R2 during reset
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    tag = "R2"; do_op(2'b11, 9); do_op(2'b11, 63);

    tag = "R5"; do_op(2'b01, 0); do_op(2'b11, 0);
    tag = "R4"; do_op(2'b00, 0); do_op(2'b01, 0); do_op(2'b10, 40);
    tag = "R9"; do_op(2'b11, 1); do_op(2'b11, 16); do_op(2'b11, 48);
    tag = "R3"; do_op(2'b11, 0);
    tag = "R5"; do_op(2'b10, 0); do_op(2'b11, 0); do_op(2'b10, 0); do_op(2'b11, 0);
    tag = "R6"; do_op(2'b10, 7); do_op(2'b01, 7); do_op(2'b11, 7);
    do_op(2'b10, 7); do_op(2'b11, 7);
    tag = "R10"; do_op(2'b01, 33); do_op(2'b00, 33); do_op(2'b00, 33); do_op(2'b11, 33);

    // R7 and R8: 255 increments must stop at 254, not wrap to zero
    tag = "R7";
    for (int i = 0; i < 255; i++) do_op(2'b01, 5);
    do_op(2'b11, 5);
    for (int i = 0; i < 253; i++) do_op(2'b10, 5);
    tag = "R8"; do_op(2'b11, 5); do_op(2'b10, 5); do_op(2'b11, 5);
    tag = "R9"; do_op(2'b11, 37); do_op(2'b11, 21);

    // random traffic on a small address subset so counts rise and fall
    tag = "R5";
    for (int i = 0; i < 4000; i++) begin
      int a;
      int r;
      a = (($urandom_range(0, 7)) * 9) % NROWS;
      r = $urandom_range(0, 9);
      if (r < 3)      do_op(2'b01, a);
      else if (r < 6) do_op(2'b10, a);
      else if (r < 9) do_op(2'b11, a);
      else            do_op(2'b00, a);
    end
    @(negedge clk); check_out();
    done = 1;
    finish_run();
  end
endmodule